// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This engine gives a host access to a bank of 16-bit registers that sit inside a PHY and have no address on the system bus. The PHY can only be reached through a single control word driven by the engine and a single status word returned by the PHY. The control word carries a 16-bit field plus four strobes. The status word carries an acknowledge flag plus 16 bits of read data. Every step of an access raises one strobe, waits for the acknowledge to rise, drops the strobe and then waits for the acknowledge to fall. This is a four-phase handshake.

The host presents an operation, which is a read or a write with an address and write data, on a valid/ready request port. `req_ready` is high only while the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While an access is in flight, `req_ready` stays low, and the host must hold or withdraw its request; nothing it drives is looked at. Completion is signalled by a one-cycle `rsp_done` pulse. `rsp_err` and `rsp_rdata` are valid with that pulse and hold until the next acceptance. Every acknowledge wait is bounded. The acknowledge is sampled at most `POLL_TRIES` times, `POLL_GAP` clock cycles apart. If the expected level is never seen, the access is abandoned with an error.

Top module: `phy_indirect_seq`

## Requirements
- R1: After reset the engine is idle: `req_ready`=1, `busy`=0, `rsp_done`=0, `phy_ctrl`=0.
- R2: A request is accepted only on an edge with `req_valid`=1 and `req_ready`=1. From that edge until the edge that raises `rsp_done`, `busy`=1 and `req_ready`=0, and requests presented meanwhile have no effect.
- R3: `phy_ctrl` layout: bits 15:0 carry address or data. Bit 16 is capture-address, bit 17 is capture-data, bit 18 is write and bit 19 is read. At most one of bits 19:16 is high at any time.
- R4: Every access starts with an address phase. In the cycle after acceptance, `phy_ctrl` is the address with no strobe. Next comes address plus capture-address until ack rises, then the address alone until ack falls.
- R5: A read then drives only the read strobe until ack rises. It captures status bits 15:0 into `rsp_rdata` at that sample, then drives zero until ack falls and completes.
- R6: A write then drives the data alone, then data plus capture-data until ack rises, then data alone until ack falls. After that it drives the write strobe alone until ack rises, then data alone until ack falls, and completes with `phy_ctrl` back at zero.
- R7: A strobe is never dropped before ack has been seen high, except when the access is aborted by a timeout. A strobe is never raised while the previous acknowledge is still high.
- R8: The acknowledge flag is status bit 16. Each wait samples it first in the cycle the wait begins, then every `POLL_GAP` cycles, at most `POLL_TRIES` times. If the expected level is not seen, the next edge gives `rsp_done`=1, `rsp_err`=1, `phy_ctrl`=0 and idle. A later request then runs normally.
- R9: `rsp_done` is high for exactly one cycle per accepted request. `rsp_err` is 0 on a completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in flight |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access ended by timeout |
| rsp_rdata | output | 16 | Read result |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
The address-only control word is due one cycle after the accepting edge, and `busy`/`req_ready` change on that same edge. `rsp_done`, `rsp_err` and `rsp_rdata` appear on the edge after the final acknowledge sample. A timeout in the first wait therefore completes exactly 2 + (POLL_TRIES-1)·POLL_GAP cycles after acceptance. The bench drives on falling edges and samples on falling edges. It counts cycles from acceptance, so each check lands in the cycle the result is due. Its PHY model answers each strobe after a random delay, so accesses of varying length all still have to show the same strobe order and data integrity.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_SET,
    ST_ADR_CAP,
    ST_ADR_REL,
    ST_RD_STB,
    ST_RD_REL,
    ST_WD_SET,
    ST_WD_CAP,
    ST_WD_REL,
    ST_WR_STB,
    ST_WR_REL
  } step_t;

  // strobe offsets above the data field of the control word
  localparam int STB_CAP_ADR = 0;
  localparam int STB_CAP_DAT = 1;
  localparam int STB_WRITE   = 2;
  localparam int STB_READ    = 3;
  localparam int STB_COUNT   = 4;

endpackage

// File: rtl/phyacc_poll.sv
module phyacc_poll #(
  parameter int POLL_GAP   = 50,
  parameter int POLL_TRIES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic waiting,
  input  logic want,
  input  logic ack,
  output logic hit,
  output logic miss
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int TW = $clog2(POLL_TRIES + 1);

  logic [GW-1:0] gap_q;
  logic [TW-1:0] try_q;
  logic          sample;

  assign sample = waiting && (gap_q == '0);
  assign hit    = sample && (ack == want);
  assign miss   = sample && (ack != want) && (try_q == TW'(POLL_TRIES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      try_q <= '0;
    end else if (arm) begin
      gap_q <= '0;
      try_q <= '0;
    end else if (sample && !hit && !miss) begin
      try_q <= try_q + 1'b1;
      gap_q <= GW'(POLL_GAP - 1);
    end else if (waiting && gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assert_try_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    try_q < TW'(POLL_TRIES));
  assert_gap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < GW'(POLL_GAP));

endmodule

// File: rtl/phyacc_fsm.sv
module phyacc_fsm
  import phyacc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [DATA_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          req_ready,
  output logic                          busy,
  input  logic [DATA_W:0]               stat,
  input  logic                          hit,
  input  logic                          miss,
  output logic                          arm,
  output logic                          waiting,
  output logic                          want,
  output logic [DATA_W+STB_COUNT-1:0]   ctrl,
  output logic                          rsp_done,
  output logic                          rsp_err,
  output logic [DATA_W-1:0]             rsp_rdata
);
  localparam int CW = DATA_W + STB_COUNT;

  step_t             st_q, st_d;
  logic [DATA_W-1:0] addr_q, data_q, rdata_q;
  logic              wr_q, done_q, err_q;
  logic              accept, finish, strobe_any;

  assign accept     = req_valid && (st_q == ST_IDLE);
  assign req_ready  = (st_q == ST_IDLE);
  assign busy       = (st_q != ST_IDLE);
  assign arm        = (st_d != st_q);
  assign strobe_any = |ctrl[CW-1:DATA_W];

  always_comb begin
    case (st_q)
      ST_ADR_CAP, ST_ADR_REL, ST_RD_STB, ST_RD_REL,
      ST_WD_CAP, ST_WD_REL, ST_WR_STB, ST_WR_REL: waiting = 1'b1;
      default:                                    waiting = 1'b0;
    endcase
    case (st_q)
      ST_ADR_CAP, ST_RD_STB, ST_WD_CAP, ST_WR_STB: want = 1'b1;
      default:                                     want = 1'b0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    finish = 1'b0;
    if (miss) begin
      st_d   = ST_IDLE;
      finish = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE:    if (accept) st_d = ST_ADR_SET;
        ST_ADR_SET: st_d = ST_ADR_CAP;
        ST_ADR_CAP: if (hit) st_d = ST_ADR_REL;
        ST_ADR_REL: if (hit) st_d = wr_q ? ST_WD_SET : ST_RD_STB;
        ST_RD_STB:  if (hit) st_d = ST_RD_REL;
        ST_RD_REL:  if (hit) begin st_d = ST_IDLE; finish = 1'b1; end
        ST_WD_SET:  st_d = ST_WD_CAP;
        ST_WD_CAP:  if (hit) st_d = ST_WD_REL;
        ST_WD_REL:  if (hit) st_d = ST_WR_STB;
        ST_WR_STB:  if (hit) st_d = ST_WR_REL;
        ST_WR_REL:  if (hit) begin st_d = ST_IDLE; finish = 1'b1; end
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl = '0;
    case (st_q)
      ST_ADR_SET, ST_ADR_REL: ctrl[DATA_W-1:0] = addr_q;
      ST_ADR_CAP: begin
        ctrl[DATA_W-1:0]             = addr_q;
        ctrl[DATA_W + STB_CAP_ADR]   = 1'b1;
      end
      ST_RD_STB:  ctrl[DATA_W + STB_READ] = 1'b1;
      ST_WD_SET, ST_WD_REL, ST_WR_REL: ctrl[DATA_W-1:0] = data_q;
      ST_WD_CAP: begin
        ctrl[DATA_W-1:0]             = data_q;
        ctrl[DATA_W + STB_CAP_DAT]   = 1'b1;
      end
      ST_WR_STB:  ctrl[DATA_W + STB_WRITE] = 1'b1;
      default:    ctrl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_wdata;
        wr_q   <= req_write;
        err_q  <= 1'b0;
      end
      if (miss) err_q <= 1'b1;
      if (st_q == ST_RD_STB && hit) rdata_q <= stat[DATA_W-1:0];
    end
  end

  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctrl[CW-1:DATA_W]) <= 1);
  assert_addr_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ctrl == {{STB_COUNT{1'b0}}, $past(req_addr)});
  assert_drop_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_any) |-> ($past(stat[DATA_W]) || (rsp_done && rsp_err)));
  assert_abort_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (rsp_done && rsp_err && ctrl == '0 && req_ready));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (req_ready && !busy));

endmodule

// File: rtl/phy_indirect_seq.sv
module phy_indirect_seq
  import phyacc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int POLL_GAP   = 50,
  parameter int POLL_TRIES = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [DATA_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        busy,
  output logic                        rsp_done,
  output logic                        rsp_err,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [DATA_W+STB_COUNT-1:0] phy_ctrl,
  input  logic [DATA_W:0]             phy_stat
);
  logic arm, waiting, want, hit, miss;

  phyacc_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .busy      (busy),
    .stat      (phy_stat),
    .hit       (hit),
    .miss      (miss),
    .arm       (arm),
    .waiting   (waiting),
    .want      (want),
    .ctrl      (phy_ctrl),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  phyacc_poll #(.POLL_GAP(POLL_GAP), .POLL_TRIES(POLL_TRIES)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .waiting (waiting),
    .want    (want),
    .ack     (phy_stat[DATA_W]),
    .hit     (hit),
    .miss    (miss)
  );

endmodule

// File: tb/sim_phy_indirect_seq.sv
`timescale 1ns/1ps
module sim_phy_indirect_seq;
  localparam int DW = 16, GAP = 50, TRIES = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready, busy, rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  always #10 clk = ~clk;

  phy_indirect_seq #(.DATA_W(DW), .POLL_GAP(GAP), .POLL_TRIES(TRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .phy_ctrl(phy_ctrl), .phy_stat(phy_stat));

  // PHY model
  logic [15:0] mem [64];
  logic [15:0] lat_addr, lat_data, rd_q;
  logic [19:0] prev_ctrl;
  logic ack, suppress = 1'b0, stuck = 1'b0;
  int cnt, tgt;
  int n_ca, n_cd, n_wr, n_rd, bad_multi, bad_raise, bad_pre;

  assign phy_stat = {ack, rd_q};

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(posedge clk) begin
    prev_ctrl <= phy_ctrl;
    if (!rst_n) begin
      ack <= 1'b0; cnt <= 0; tgt <= 1; rd_q <= '0;
      lat_addr <= '0; lat_data <= '0;
    end else begin
      if (phy_ctrl[19:16] != 4'b0 && !ack) begin
        if (!suppress) begin
          if (cnt >= tgt) begin
            ack <= 1'b1; cnt <= 0; tgt <= int'($urandom_range(0, 5));
            if (phy_ctrl[16]) lat_addr <= phy_ctrl[15:0];
            if (phy_ctrl[17]) lat_data <= phy_ctrl[15:0];
            if (phy_ctrl[18]) mem[lat_addr[5:0]] <= lat_data;
            if (phy_ctrl[19]) rd_q <= mem[lat_addr[5:0]];
          end else cnt <= cnt + 1;
        end
      end else if (phy_ctrl[19:16] == 4'b0 && ack) begin
        if (!stuck) begin
          if (cnt >= tgt) begin
            ack <= 1'b0; cnt <= 0; tgt <= int'($urandom_range(0, 5));
          end else cnt <= cnt + 1;
        end
      end else cnt <= 0;
      // protocol monitor
      if ($countones(phy_ctrl[19:16]) > 1) bad_multi <= bad_multi + 1;
      if (phy_ctrl[19:16] != 4'b0 && prev_ctrl[19:16] == 4'b0) begin
        if (ack) bad_raise <= bad_raise + 1;
        if ((phy_ctrl[16] || phy_ctrl[17]) && prev_ctrl[15:0] != phy_ctrl[15:0])
          bad_pre <= bad_pre + 1;
        if (phy_ctrl[16]) n_ca <= n_ca + 1;
        if (phy_ctrl[17]) n_cd <= n_cd + 1;
        if (phy_ctrl[18]) n_wr <= n_wr + 1;
        if (phy_ctrl[19]) n_rd <= n_rd + 1;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       output logic [15:0] rdata, output bit err,
                       output int cyc, output logic [19:0] first);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    first = phy_ctrl;
    cyc = 1;
    while (!rsp_done) begin @(negedge clk); cyc++; end
    rdata = rsp_rdata; err = rsp_err;
  endtask

  // op, addr, data (expected data for reads)
  localparam logic [32:0] VEC [9] = '{
    {1'b1, 16'h0021, 16'hA5C3}, {1'b1, 16'h0ABC, 16'h1234},
    {1'b1, 16'hFFFF, 16'hFFFF}, {1'b0, 16'h0021, 16'hA5C3},
    {1'b0, 16'h0ABC, 16'h1234}, {1'b1, 16'h0021, 16'h0000},
    {1'b0, 16'h0021, 16'h0000}, {1'b0, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h0007, 16'h0000}};

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [19:0] first;
    bit err;
    int cyc, dones;
    n_ca = 0; n_cd = 0; n_wr = 0; n_rd = 0;
    bad_multi = 0; bad_raise = 0; bad_pre = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1 && busy == 1'b0, "R1 ready/busy", {req_ready, busy}, 2'b10);
    check(phy_ctrl == '0 && rsp_done == 1'b0, "R1 ctrl/done", int'(phy_ctrl), 0);

    for (int i = 0; i < 9; i++) begin
      bit wr;
      logic [15:0] a, d;
      int ca0, cd0, wr0, rd0;
      wr = VEC[i][32]; a = VEC[i][31:16]; d = VEC[i][15:0];
      ca0 = n_ca; cd0 = n_cd; wr0 = n_wr; rd0 = n_rd;
      do_op(wr, a, d, rd, err, cyc, first);
      check(err == 1'b0, "R9 no error", int'(err), 0);
      check(first == {4'b0, a}, "R4 address first", int'(first), int'({4'b0, a}));
      @(negedge clk);
      check(rsp_done == 1'b0, "R9 single-cycle done", int'(rsp_done), 0);
      check(phy_ctrl == '0, "R6 ctrl zero at end", int'(phy_ctrl), 0);
      if (wr)
        check(n_ca - ca0 == 1 && n_cd - cd0 == 1 && n_wr - wr0 == 1 && n_rd == rd0,
              "R6 write strobes", (n_ca-ca0)*100 + (n_cd-cd0)*10 + (n_wr-wr0), 111);
      else begin
        check(rd == d, "R5 read data", int'(rd), int'(d));
        check(n_ca - ca0 == 1 && n_rd - rd0 == 1 && n_cd == cd0 && n_wr == wr0,
              "R5 read strobes", (n_ca-ca0)*10 + (n_rd-rd0), 11);
      end
    end

    // R2: requests during busy are ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0007; req_wdata = 16'h5555;
    @(negedge clk);
    check(busy == 1'b1 && req_ready == 1'b0, "R2 busy after accept", {busy, req_ready}, 2'b10);
    req_wdata = 16'h9999; req_addr = 16'h0008;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    dones = 0;
    while (busy) begin @(negedge clk); if (rsp_done) dones++; end
    repeat (3) @(negedge clk);
    check(dones == 1 && busy == 1'b0, "R2 one completion", dones, 1);
    do_op(1'b0, 16'h0007, 16'h0, rd, err, cyc, first);
    check(rd == 16'h5555, "R2 ignored request left data", int'(rd), 16'h5555);
    do_op(1'b0, 16'h0008, 16'h0, rd, err, cyc, first);
    check(rd == 16'h0000, "R2 ignored request wrote nothing", int'(rd), 0);

    // R8: ack never rises -> timeout in first wait, exact length
    suppress = 1'b1;
    do_op(1'b0, 16'h0ABC, 16'h0, rd, err, cyc, first);
    check(err == 1'b1, "R8 timeout error", int'(err), 1);
    check(cyc == 3 + (TRIES - 1) * GAP, "R8 timeout cycles", cyc, 3 + (TRIES - 1) * GAP);
    check(phy_ctrl == '0 && req_ready == 1'b1, "R8 idle after abort", int'(phy_ctrl), 0);
    suppress = 1'b0;
    repeat (5) @(negedge clk);

    // R8: ack never falls -> timeout in release wait
    stuck = 1'b1;
    do_op(1'b1, 16'h0ABC, 16'hDEAD, rd, err, cyc, first);
    check(err == 1'b1, "R8 stuck-ack error", int'(err), 1);
    check(phy_ctrl == '0, "R8 ctrl zero after abort", int'(phy_ctrl), 0);
    stuck = 1'b0;
    repeat (20) @(negedge clk);

    // R8 recovery: old data intact, normal access works
    do_op(1'b0, 16'h0ABC, 16'h0, rd, err, cyc, first);
    check(err == 1'b0 && rd == 16'h1234, "R8 recovery read", int'(rd), 16'h1234);

    // R3 / R7 / R4 protocol monitor results
    check(bad_multi == 0, "R3 one strobe at a time", bad_multi, 0);
    check(bad_raise == 0, "R7 strobe raised with ack high", bad_raise, 0);
    check(bad_pre == 0, "R4 field set before capture strobe", bad_pre, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule